// File: doc/BRIEF.md
# General Purpose Event Enable Controller

This block holds a 32-bit power-management enable register and a status register with the same layout. Together they decide which hardware events reach the system control interrupt (SCI), the system management interrupt (SMI) and the wake request. It watches sixteen general-purpose inputs and a small set of dedicated sources: two USB wake sources, a bus-0 PME source, a general PME source, a PCI Express wake source and an active-low low-battery pin. When a source's event edge arrives, its sticky status bit is set. Each output is the OR of the status-and-enable pairs that are routed to it.

The enable bits are split across two reset domains. The bits for the low-battery, PME and bus-0 PME sources sit in the RTC domain. All other implemented bits sit in the resume domain. An override or thermal-trip input clears every enable bit. A strobe for a write to the platform reset register clears only the resume-domain enables. Software reads both registers at any time and writes them through one shared data bus. Status bits are cleared by writing 1 to them.

Top module: `gpe_enable_ctrl`

## Requirements
- R1: `en_rdata` always shows the enable register without delay. A write on `en_wr` takes effect at the next rising clock edge. The implemented bits are 31:16 (general-purpose input n at bit 16+n), 14 (USB wake 4), 13 (bus-0 PME), 12 (USB wake 3), 11 (PME), 10 (low battery) and 9 (PCI Express). The status register uses the same positions.
- R2: Bits 15 and 8:0 of both registers read as 0, and writes to them have no effect.
- R3: `rtc_rst_n` clears enable and status bits 13, 11 and 10 and no others. `rsm_rst_n` clears all other implemented bits and leaves bits 13, 11 and 10 unchanged. Both resets clear asynchronously.
- R4: When `force_clr` is sampled high, every enable bit is 0 after that edge, even if a write happens in the same cycle.
- R5: When `rstreg_wr` is sampled high, the resume-domain enable bits are 0 after that edge, even if a write happens in the same cycle. Bits 13, 11 and 10 keep their previous value.
- R6: A status bit is set on the rising edge of its event. For the low-battery source, the event edge is the falling edge of `batlow_n`. The bit is set at the clock edge that samples the new level. A source held at a constant level does not set its bit again. Writing 1 through `sts_wr` clears a bit. If a set and a clear land in the same cycle, the set wins.
- R7: An enabled general-purpose input status drives both `sci` and `wake`. Clearing its enable drops both outputs at once.
- R8: The USB status bits (14 and 12) drive only `wake`, never `sci` or `smi`.
- R9: The PCI Express status bit (9) drives only `sci`. With enable bit 9 at 0, it drives nothing.
- R10: The PME status bit (11) drives both `wake` and `sci`.
- R11: The bus-0 PME status bit (13) drives `wake`. It also drives `sci` when `sci_mode` is 1, or `smi` when `sci_mode` is 0.
- R12: The low-battery status bit (10) drives `sci` when `sci_mode` is 1 and `smi` when `sci_mode` is 0. It never drives `wake`. While `batlow_n` is low, `wake` is 0 whatever the status and enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rsm_rst_n | input | 1 | Resume-domain reset, active low |
| rtc_rst_n | input | 1 | RTC-domain reset, active low |
| en_wr | input | 1 | Write `wdata` into the enable register |
| sts_wr | input | 1 | Write-1-to-clear the status register with `wdata` |
| wdata | input | 32 | Shared write data |
| en_rdata | output | 32 | Enable register contents |
| sts_rdata | output | 32 | Status register contents |
| gpi | input | 16 | General-purpose event inputs |
| usb3_wake | input | 1 | USB wake source 3 |
| usb4_wake | input | 1 | USB wake source 4 |
| pme_bus0 | input | 1 | Bus-0 PME source |
| pme_in | input | 1 | PME source |
| pcie_wake | input | 1 | PCI Express wake source |
| batlow_n | input | 1 | Low-battery pin, active low |
| sci_mode | input | 1 | 1 routes mode-switched sources to SCI, 0 routes them to SMI |
| force_clr | input | 1 | Override / thermal-trip clear of all enables |
| rstreg_wr | input | 1 | Platform reset register write strobe |
| sci | output | 1 | System control interrupt request |
| smi | output | 1 | System management interrupt request |
| wake | output | 1 | Wake request |

## Verification
The collision that matters most is a source's event edge arriving in the same cycle as a write-1 clear of its own status bit. The bench provokes it by raising USB wake 3 while writing 1 to bit 12. It passes only if the status reads 1 afterwards, so the event is not lost to the clear. The same pattern is applied to an enable write landing in the same cycle as the override clear and as the platform reset strobe. In those cases the clear must win for the bits it owns. A cycle-by-cycle reference model judges all three, and a named check follows each one.

// File: rtl/gpe_pkg.sv
`timescale 1ns/1ps
package gpe_pkg;

  localparam int REG_W      = 32;
  localparam int GPI_LSB    = 16;
  localparam int BIT_PCIE   = 9;
  localparam int BIT_LOWBAT = 10;
  localparam int BIT_PME    = 11;
  localparam int BIT_USB3   = 12;
  localparam int BIT_PME_B0 = 13;
  localparam int BIT_USB4   = 14;

  // Sources whose enable and status survive a resume-domain reset.
  localparam logic [REG_W-1:0] RTC_WELL_MASK =
    (REG_W'(1) << BIT_LOWBAT) | (REG_W'(1) << BIT_PME) | (REG_W'(1) << BIT_PME_B0);

  // Dedicated (non general-purpose) sources.
  localparam logic [REG_W-1:0] FIXED_SRC_MASK =
    (REG_W'(1) << BIT_PCIE) | (REG_W'(1) << BIT_LOWBAT) | (REG_W'(1) << BIT_PME) |
    (REG_W'(1) << BIT_USB3) | (REG_W'(1) << BIT_PME_B0) | (REG_W'(1) << BIT_USB4);

  function automatic logic [REG_W-1:0] impl_mask(input int n_gpi);
    logic [REG_W-1:0] m;
    m = FIXED_SRC_MASK;
    for (int k = 0; k < n_gpi; k++) m[GPI_LSB + k] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic sci;
    logic smi;
    logic wake;
  } gpe_req_t;

endpackage

// File: rtl/gpe_rst_sync.sv
`timescale 1ns/1ps
module gpe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin : p_next
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin : p_reg
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/gpe_dual_well_bank.sv
`timescale 1ns/1ps
module gpe_dual_well_bank #(
  parameter int             W         = 32,
  parameter logic [W-1:0]   RTC_MASK  = '0,
  parameter logic [W-1:0]   IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rsm_rst_n,
  input  logic         rtc_rst_n,
  input  logic [W-1:0] ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (!IMPL_MASK[i]) begin : g_resv
      logic unused_in;
      assign unused_in = ld[i] ^ d[i];
      assign q[i] = 1'b0;
    end else if (RTC_MASK[i]) begin : g_rtc
      logic q_r;
      always_ff @(posedge clk or negedge rtc_rst_n) begin : p_reg
        if (!rtc_rst_n)  q_r <= 1'b0;
        else if (ld[i])  q_r <= d[i];
      end
      assign q[i] = q_r;
    end else begin : g_rsm
      logic q_r;
      always_ff @(posedge clk or negedge rsm_rst_n) begin : p_reg
        if (!rsm_rst_n)  q_r <= 1'b0;
        else if (ld[i])  q_r <= d[i];
      end
      assign q[i] = q_r;
    end
  end

endmodule

// File: rtl/gpe_edge_detect.sv
`timescale 1ns/1ps
module gpe_edge_detect #(
  parameter int           W         = 32,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  output logic [W-1:0] rise
);

  logic [W-1:0] hist_q;
  logic [W-1:0] hist_d;

  always_comb begin : p_next
    hist_d = ev & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin : p_reg
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign rise = ev & IMPL_MASK & ~hist_q;

endmodule

// File: rtl/gpe_event_router.sv
`timescale 1ns/1ps
module gpe_event_router
  import gpe_pkg::*;
#(
  parameter int NUM_GPI = 16
) (
  input  logic [REG_W-1:0] sts,
  input  logic [REG_W-1:0] en,
  input  logic             sci_mode,
  input  logic             batlow_n,
  output gpe_req_t         req
);

  logic [REG_W-1:0] act;
  logic             gpi_hit;
  logic             mode_hit;
  logic             wake_raw;
  logic             unused_act;

  assign act        = sts & en;
  assign gpi_hit    = |act[GPI_LSB +: NUM_GPI];
  assign mode_hit   = act[BIT_PME_B0] | act[BIT_LOWBAT];
  assign unused_act = ^{act[GPI_LSB-1], act[BIT_PCIE-1:0]};

  assign wake_raw = gpi_hit | act[BIT_USB4] | act[BIT_USB3] |
                    act[BIT_PME_B0] | act[BIT_PME];

  always_comb begin : p_route
    req.sci  = gpi_hit | act[BIT_PME] | act[BIT_PCIE] | (sci_mode & mode_hit);
    req.smi  = ~sci_mode & mode_hit;
    req.wake = wake_raw & batlow_n;
  end

endmodule

// File: rtl/gpe_enable_ctrl.sv
`timescale 1ns/1ps
module gpe_enable_ctrl
  import gpe_pkg::*;
#(
  parameter int NUM_GPI     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rsm_rst_n,
  input  logic               rtc_rst_n,
  input  logic               en_wr,
  input  logic               sts_wr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   en_rdata,
  output logic [REG_W-1:0]   sts_rdata,
  input  logic [NUM_GPI-1:0] gpi,
  input  logic               usb3_wake,
  input  logic               usb4_wake,
  input  logic               pme_bus0,
  input  logic               pme_in,
  input  logic               pcie_wake,
  input  logic               batlow_n,
  input  logic               sci_mode,
  input  logic               force_clr,
  input  logic               rstreg_wr,
  output logic               sci,
  output logic               smi,
  output logic               wake
);

  localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_GPI);

  logic             rsm_rst_sync_n;
  logic             rtc_rst_sync_n;
  logic [REG_W-1:0] ev;
  logic [REG_W-1:0] rise;
  logic [REG_W-1:0] en_q, en_d, en_ld;
  logic [REG_W-1:0] sts_q, sts_d, sts_ld, sts_clr;
  gpe_req_t         req;

  gpe_rst_sync #(.STAGES(SYNC_STAGES)) u_rsm_sync (
    .clk(clk), .arst_n(rsm_rst_n), .rst_n_o(rsm_rst_sync_n));
  gpe_rst_sync #(.STAGES(SYNC_STAGES)) u_rtc_sync (
    .clk(clk), .arst_n(rtc_rst_n), .rst_n_o(rtc_rst_sync_n));

  // Event vector in register bit order.
  always_comb begin : p_events
    ev                       = '0;
    ev[GPI_LSB +: NUM_GPI]   = gpi;
    ev[BIT_USB4]             = usb4_wake;
    ev[BIT_PME_B0]           = pme_bus0;
    ev[BIT_USB3]             = usb3_wake;
    ev[BIT_PME]              = pme_in;
    ev[BIT_LOWBAT]           = ~batlow_n;
    ev[BIT_PCIE]             = pcie_wake;
  end

  gpe_edge_detect #(.W(REG_W), .IMPL_MASK(IMPL)) u_edge (
    .clk(clk), .rst_n(rsm_rst_sync_n), .ev(ev), .rise(rise));

  // Enable next state: override beats reset-register strobe beats write.
  always_comb begin : p_en_next
    en_d = en_q;
    if (en_wr)     en_d = wdata & IMPL;
    if (rstreg_wr) en_d = en_d & RTC_WELL_MASK;
    if (force_clr) en_d = '0;
    en_ld = {REG_W{en_wr | rstreg_wr | force_clr}};
  end

  // Status next state: new event beats write-1-clear.
  always_comb begin : p_sts_next
    sts_clr = sts_wr ? wdata : '0;
    sts_d   = (sts_q & ~sts_clr) | rise;
    sts_ld  = sts_clr | rise;
  end

  gpe_dual_well_bank #(.W(REG_W), .RTC_MASK(RTC_WELL_MASK), .IMPL_MASK(IMPL)) u_en_bank (
    .clk(clk), .rsm_rst_n(rsm_rst_sync_n), .rtc_rst_n(rtc_rst_sync_n),
    .ld(en_ld), .d(en_d), .q(en_q));

  gpe_dual_well_bank #(.W(REG_W), .RTC_MASK(RTC_WELL_MASK), .IMPL_MASK(IMPL)) u_sts_bank (
    .clk(clk), .rsm_rst_n(rsm_rst_sync_n), .rtc_rst_n(rtc_rst_sync_n),
    .ld(sts_ld), .d(sts_d), .q(sts_q));

  gpe_event_router #(.NUM_GPI(NUM_GPI)) u_router (
    .sts(sts_q), .en(en_q), .sci_mode(sci_mode), .batlow_n(batlow_n), .req(req));

  assign en_rdata  = en_q;
  assign sts_rdata = sts_q;
  assign sci       = req.sci;
  assign smi       = req.smi;
  assign wake      = req.wake;

endmodule

// File: rtl/gpe_enable_ctrl_chk.sv
`timescale 1ns/1ps
module gpe_enable_ctrl_chk
  import gpe_pkg::*;
#(
  parameter int NUM_GPI = 16
) (
  input logic             clk,
  input logic             rsm_rst_n,
  input logic             rtc_rst_n,
  input logic             sts_wr,
  input logic             en_wr,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] en_rdata,
  input logic [REG_W-1:0] sts_rdata,
  input logic             batlow_n,
  input logic             sci_mode,
  input logic             force_clr,
  input logic             rstreg_wr,
  input logic             sci,
  input logic             smi,
  input logic             wake
);

  localparam logic [REG_W-1:0] IMPL     = impl_mask(NUM_GPI);
  localparam logic [REG_W-1:0] USB_BITS = (REG_W'(1) << BIT_USB3) | (REG_W'(1) << BIT_USB4);

  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rsm_rst_n || !rtc_rst_n)
    ((en_rdata | sts_rdata) & ~IMPL) == '0); // R2

  AST_OVERRIDE_CLEARS: assert property (@(posedge clk) disable iff (!rsm_rst_n || !rtc_rst_n)
    force_clr |=> (en_rdata == '0)); // R4

  AST_RSTREG_KEEPS_RTC: assert property (@(posedge clk) disable iff (!rsm_rst_n || !rtc_rst_n)
    (rstreg_wr && !force_clr && !en_wr) |=>
      ((en_rdata & RTC_WELL_MASK) == $past(en_rdata & RTC_WELL_MASK))); // R5

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rsm_rst_n || !rtc_rst_n)
    1'b1 |=> ((sts_rdata & ($past(sts_rdata) & ~$past(sts_wr ? wdata : '0))) ==
              ($past(sts_rdata) & ~$past(sts_wr ? wdata : '0)))); // R6

  AST_USB_NOT_INTR: assert property (@(posedge clk) disable iff (!rsm_rst_n || !rtc_rst_n)
    (sci || smi) |-> ((sts_rdata & en_rdata & ~USB_BITS) != '0)); // R8

  AST_SMI_ONLY_IN_SMI_MODE: assert property (@(posedge clk) disable iff (!rsm_rst_n || !rtc_rst_n)
    smi |-> !sci_mode); // R11

  AST_LOWBAT_BLOCKS_WAKE: assert property (@(posedge clk) disable iff (!rsm_rst_n || !rtc_rst_n)
    !batlow_n |-> !wake); // R12

endmodule

bind gpe_enable_ctrl gpe_enable_ctrl_chk #(.NUM_GPI(NUM_GPI)) u_chk (
  .clk(clk), .rsm_rst_n(rsm_rst_n), .rtc_rst_n(rtc_rst_n), .sts_wr(sts_wr),
  .en_wr(en_wr), .wdata(wdata), .en_rdata(en_rdata), .sts_rdata(sts_rdata),
  .batlow_n(batlow_n), .sci_mode(sci_mode), .force_clr(force_clr),
  .rstreg_wr(rstreg_wr), .sci(sci), .smi(smi), .wake(wake));

// File: tb/tb_gpe_enable_ctrl.sv
`timescale 1ns/1ps
module tb_gpe_enable_ctrl;

  localparam logic [31:0] M_IMPL = 32'hFFFF_7E00;
  localparam logic [31:0] M_RTC  = 32'h0000_2C00;

  logic clk, rsm_rst_n, rtc_rst_n, en_wr, sts_wr;
  logic [31:0] wdata, en_rdata, sts_rdata;
  logic [15:0] gpi;
  logic usb3_wake, usb4_wake, pme_bus0, pme_in, pcie_wake, batlow_n;
  logic sci_mode, force_clr, rstreg_wr, sci, smi, wake;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_en = '0, m_sts = '0, m_prev = '0;

  gpe_enable_ctrl dut (
    .clk(clk), .rsm_rst_n(rsm_rst_n), .rtc_rst_n(rtc_rst_n), .en_wr(en_wr),
    .sts_wr(sts_wr), .wdata(wdata), .en_rdata(en_rdata), .sts_rdata(sts_rdata),
    .gpi(gpi), .usb3_wake(usb3_wake), .usb4_wake(usb4_wake), .pme_bus0(pme_bus0),
    .pme_in(pme_in), .pcie_wake(pcie_wake), .batlow_n(batlow_n), .sci_mode(sci_mode),
    .force_clr(force_clr), .rstreg_wr(rstreg_wr), .sci(sci), .smi(smi), .wake(wake));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  // Behavioural reference: updated on each rising edge.
  always @(posedge clk) begin : model
    logic [31:0] ev_v, rise_v, nen, nsts;
    ev_v = '0;
    ev_v[31:16] = gpi;
    ev_v[14] = usb4_wake;  ev_v[13] = pme_bus0;  ev_v[12] = usb3_wake;
    ev_v[11] = pme_in;     ev_v[10] = ~batlow_n; ev_v[9]  = pcie_wake;
    rise_v = ev_v & ~m_prev;
    nsts = m_sts;
    if (sts_wr) nsts = nsts & ~wdata;
    nsts = (nsts | rise_v) & M_IMPL;
    nen = m_en;
    if (en_wr)     nen = wdata & M_IMPL;
    if (rstreg_wr) nen = nen & M_RTC;
    if (force_clr) nen = '0;
    m_prev = ev_v;
    if (!rsm_rst_n) begin nen = nen & M_RTC; nsts = nsts & M_RTC; m_prev = '0; end
    if (!rtc_rst_n) begin nen = nen & ~M_RTC; nsts = nsts & ~M_RTC; end
    m_en  = nen;
    m_sts = nsts;
  end

  function automatic logic [2:0] model_out(input logic [31:0] s, input logic [31:0] e,
                                           input logic mode, input logic bl_n);
    logic [31:0] a;
    logic o_sci, o_smi, o_wake;
    a = s & e;
    o_sci = 0; o_smi = 0; o_wake = 0;
    for (int b = 0; b < 32; b++) begin
      if (a[b]) begin
        if (b >= 16)                   begin o_sci = 1; o_wake = 1; end
        else if (b == 14 || b == 12)   o_wake = 1;
        else if (b == 13)              begin o_wake = 1; if (mode) o_sci = 1; else o_smi = 1; end
        else if (b == 11)              begin o_sci = 1; o_wake = 1; end
        else if (b == 10)              begin if (mode) o_sci = 1; else o_smi = 1; end
        else if (b == 9)               o_sci = 1;
      end
    end
    return {o_sci, o_smi, o_wake & bl_n};
  endfunction

  always @(negedge clk) begin : compare
    logic [2:0] eo;
    if (!finished) begin
      eo = model_out(m_sts, m_en, sci_mode, batlow_n);
      chk("R1",  "en_rdata",  en_rdata,  m_en);
      chk("R6",  "sts_rdata", sts_rdata, m_sts);
      chk("R7",  "sci",  {31'b0, sci},  {31'b0, eo[2]});
      chk("R11", "smi",  {31'b0, smi},  {31'b0, eo[1]});
      chk("R12", "wake", {31'b0, wake}, {31'b0, eo[0]});
    end
  end

  task automatic outs(input string req, input logic e_sci, input logic e_smi, input logic e_wake);
    chk(req, "sci",  {31'b0, sci},  {31'b0, e_sci});
    chk(req, "smi",  {31'b0, smi},  {31'b0, e_smi});
    chk(req, "wake", {31'b0, wake}, {31'b0, e_wake});
  endtask

  task automatic wr_en(input logic [31:0] v);
    en_wr = 1; wdata = v; tick(); en_wr = 0; wdata = '0;
  endtask

  task automatic clr_sts(input logic [31:0] v);
    sts_wr = 1; wdata = v; tick(); sts_wr = 0; wdata = '0;
  endtask

  task automatic settle(); repeat (4) tick(); endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    rsm_rst_n = 0; rtc_rst_n = 0; en_wr = 0; sts_wr = 0; wdata = '0; gpi = '0;
    usb3_wake = 0; usb4_wake = 0; pme_bus0 = 0; pme_in = 0; pcie_wake = 0;
    batlow_n = 1; sci_mode = 1; force_clr = 0; rstreg_wr = 0;
    repeat (3) tick();
    rsm_rst_n = 1; rtc_rst_n = 1;
    settle();
    chk("R3", "reset en", en_rdata, 32'h0);
    chk("R3", "reset sts", sts_rdata, 32'h0);
    outs("R3", 0, 0, 0);

    wr_en(32'hFFFF_FFFF);
    chk("R1", "enable readback", en_rdata, 32'hFFFF_7E00);
    chk("R2", "reserved enable", en_rdata & 32'h0000_81FF, 32'h0);
    clr_sts(32'hFFFF_FFFF);
    chk("R2", "status write of ones", sts_rdata, 32'h0);

    gpi = 16'h0008; tick(); gpi = '0;
    chk("R7", "gpi3 status", sts_rdata, 32'h0008_0000);
    outs("R7", 1, 0, 1);
    wr_en(32'hFFF7_7E00);
    outs("R7", 0, 0, 0);
    wr_en(32'hFFFF_FFFF);
    clr_sts(32'h0008_0000);
    chk("R6", "w1c clears", sts_rdata, 32'h0);

    gpi = 16'h0001; tick();
    chk("R6", "gpi0 set", sts_rdata, 32'h0001_0000);
    clr_sts(32'h0001_0000); tick();
    chk("R6", "level does not reset", sts_rdata, 32'h0);
    gpi = '0; tick();

    usb3_wake = 1; tick(); usb3_wake = 0;
    chk("R8", "usb3 status", sts_rdata, 32'h0000_1000);
    outs("R8", 0, 0, 1);
    clr_sts(32'h0000_1000);

    pcie_wake = 1; tick(); pcie_wake = 0;
    chk("R9", "pcie status", sts_rdata, 32'h0000_0200);
    outs("R9", 1, 0, 0);
    clr_sts(32'h0000_0200);
    wr_en(32'hFFFF_7C00);
    pcie_wake = 1; tick(); pcie_wake = 0;
    chk("R9", "pcie status disabled", sts_rdata, 32'h0000_0200);
    outs("R9", 0, 0, 0);
    clr_sts(32'h0000_0200);
    wr_en(32'hFFFF_FFFF);

    pme_in = 1; tick(); pme_in = 0;
    chk("R10", "pme status", sts_rdata, 32'h0000_0800);
    outs("R10", 1, 0, 1);
    clr_sts(32'h0000_0800);

    pme_bus0 = 1; tick(); pme_bus0 = 0;
    chk("R11", "bus0 pme status", sts_rdata, 32'h0000_2000);
    outs("R11", 1, 0, 1);
    sci_mode = 0; #1;
    outs("R11", 0, 1, 1);
    sci_mode = 1;
    clr_sts(32'h0000_2000);

    usb4_wake = 1; tick(); usb4_wake = 0;
    outs("R8", 0, 0, 1);
    batlow_n = 0; tick();
    chk("R12", "lowbat status", sts_rdata, 32'h0000_4400);
    outs("R12", 1, 0, 0);
    sci_mode = 0; #1;
    outs("R12", 0, 1, 0);
    batlow_n = 1; #1;
    outs("R12", 0, 1, 1);
    sci_mode = 1;
    clr_sts(32'hFFFF_FFFF);
    chk("R6", "all cleared", sts_rdata, 32'h0);

    usb3_wake = 1; sts_wr = 1; wdata = 32'h0000_1000; tick();
    sts_wr = 0; wdata = '0; usb3_wake = 0;
    chk("R6", "set wins over clear", sts_rdata, 32'h0000_1000);
    clr_sts(32'h0000_1000);

    rstreg_wr = 1; tick(); rstreg_wr = 0;
    chk("R5", "rstreg keeps rtc bits", en_rdata, 32'h0000_2C00);
    wr_en(32'hFFFF_FFFF);
    rstreg_wr = 1; en_wr = 1; wdata = 32'hFFFF_FFFF; tick();
    rstreg_wr = 0; en_wr = 0; wdata = '0;
    chk("R5", "rstreg beats write", en_rdata, 32'h0000_2C00);

    wr_en(32'hFFFF_FFFF);
    force_clr = 1; en_wr = 1; wdata = 32'hFFFF_FFFF; tick();
    force_clr = 0; en_wr = 0; wdata = '0;
    chk("R4", "override beats write", en_rdata, 32'h0);

    wr_en(32'hFFFF_FFFF);
    pme_in = 1; usb3_wake = 1; tick(); pme_in = 0; usb3_wake = 0;
    rtc_rst_n = 0; tick();
    chk("R3", "rtc reset enables", en_rdata, 32'hFFFF_5200);
    chk("R3", "rtc reset status", sts_rdata, 32'h0000_1000);
    rtc_rst_n = 1; settle();
    wr_en(32'hFFFF_FFFF);
    pme_in = 1; tick(); pme_in = 0;
    rsm_rst_n = 0; tick();
    chk("R3", "resume reset enables", en_rdata, 32'h0000_2C00);
    chk("R3", "resume reset status", sts_rdata, 32'h0000_0800);
    outs("R10", 1, 0, 1);
    rsm_rst_n = 1; settle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule